// File: doc/BRIEF.md
# Boolean Function Equivalence Classifier

This block takes the 8-entry truth table of a three-input Boolean function and reduces it to a canonical representative of its equivalence class. Three relations are available. The first permits only reordering of the inputs. The second also permits complementing any subset of inputs. The third further permits complementing the output. The representative is the smallest unsigned truth-table value reachable under the transforms the chosen relation allows. The block also reports the transform that produced the representative, and it flags every input on which the function does not depend.

A client presents a truth table and a relation code, then pulses `start`. The engine tries one candidate transform per clock and keeps a running minimum. When the search ends it raises `done` for one cycle. The results then stay unchanged until the next accepted start. Two functions belong to the same class exactly when their representatives match, so a cell-matching tool can use the result as a lookup key.

Truth-table bit `i` holds the output for the input vector {x3,x2,x1} = i, where x1 is bit 0 of `i`.

Top module: `npnClassifier`

## Requirements
- R1: While reset is held and in the first idle cycle after reset, `busy`, `done`, `canon`, `permIdx`, `negMask`, `outNeg` and `degen` are all zero.
- R2: A `start` seen while idle is accepted at that clock edge. `busy` is then high for exactly N cycles. In the cycle after the last busy cycle, `busy` is low and `done` is high for exactly one cycle.
- R3: A `start` raised while `busy` is high is ignored. Changes on `truthIn` and `mode` during the search do not alter the result or the cycle count.
- R4: The mode code selects N. Code 0 gives permutation only (N=6). Code 1 gives permutation and input negation (N=48). Codes 2 and 3 give permutation, input negation and output negation (N=96).
- R5: A candidate (p, m, o) maps truth table f to g as follows. For each i, let z = i XOR m. Let y be the vector whose bit k is bit S_p(k) of z. Then g[i] = f[y] XOR o. The selection tuples (S_p(0), S_p(1), S_p(2)) are: p=0 (0,1,2), p=1 (0,2,1), p=2 (1,0,2), p=3 (1,2,0), p=4 (2,0,1), p=5 (2,1,0).
- R6: `canon` is the minimum unsigned value of g over the allowed candidates. The search order runs p fastest, then m, then o (0 before 1). On equal values, the earliest candidate in that order is reported.
- R7: `permIdx`, `negMask` and `outNeg` give the (p, m, o) of the reported candidate. In code 0, `negMask` and `outNeg` are zero. In code 1, `outNeg` is zero.
- R8: `degen` bit k-1 is set exactly when f(x) equals f(x with xk complemented) for every x. The flags are computed on the truth table that was accepted.
- R9: Once `done` has pulsed, all result outputs hold their values until the next accepted start, whatever `truthIn` and `mode` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a classification |
| mode | input | 2 | Equivalence relation code |
| truthIn | input | 8 | Truth table of the function |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| canon | output | 8 | Canonical representative |
| permIdx | output | 3 | Permutation index of the result |
| negMask | output | 3 | Input-negation mask of the result |
| outNeg | output | 1 | Output-negation flag of the result |
| degen | output | 3 | Per-input independence flags |

## Verification
The bench targets ties, which arise in constant functions and fully symmetric ones such as majority, parity and AND. A design that replaced its best candidate on equal values would report a later permutation or mask than expected. Mode boundaries are checked through the exact busy length and the reported fields. A design whose counter wrapped wrongly would either stop early or allow output negation in mode 1, and that would show up as a smaller representative than expected. A second start arrives mid-search with a different table; a design that accepted it would change its result or its cycle count. Constants and single-variable functions test the degeneracy flags, and a cofactor taken on the wrong bit would flag the wrong input.

// File: rtl/npnClassPkg.sv
package npnClassPkg;

  localparam int NumIn   = 3;
  localparam int TtW     = 1 << NumIn;
  localparam int NumPerm = 6;
  localparam int PermW   = 3;
  localparam int SelW    = 2;

  typedef enum logic [1:0] {
    ModeP      = 2'd0,
    ModeNp     = 2'd1,
    ModeNpn    = 2'd2,
    ModeNpnAlt = 2'd3
  } modeT;

  typedef struct packed {
    logic             load;
    logic             eval;
    logic [PermW-1:0] perm;
    logic [NumIn-1:0] mask;
    logic             pol;
  } strobeT;

  // packed selection tuple {S(2), S(1), S(0)} for permutation index p
  function automatic logic [NumIn*SelW-1:0] permSel(input logic [PermW-1:0] p);
    logic [NumIn*SelW-1:0] s;
    case (p)
      3'd0:    s = {2'd2, 2'd1, 2'd0};
      3'd1:    s = {2'd1, 2'd2, 2'd0};
      3'd2:    s = {2'd2, 2'd0, 2'd1};
      3'd3:    s = {2'd0, 2'd2, 2'd1};
      3'd4:    s = {2'd1, 2'd0, 2'd2};
      default: s = {2'd0, 2'd1, 2'd2};
    endcase
    return s;
  endfunction

  function automatic logic [TtW-1:0] applyXform(input logic [TtW-1:0]   tt,
                                                input logic [PermW-1:0] p,
                                                input logic [NumIn-1:0] m,
                                                input logic             o);
    logic [TtW-1:0]        g;
    logic [NumIn*SelW-1:0] s;
    logic [NumIn-1:0]      z;
    logic [NumIn-1:0]      y;
    s = permSel(p);
    for (int i = 0; i < TtW; i++) begin
      z = NumIn'(i) ^ m;
      for (int k = 0; k < NumIn; k++) begin
        y[k] = z[s[k*SelW +: SelW]];
      end
      g[i] = tt[y] ^ o;
    end
    return g;
  endfunction

endpackage

// File: rtl/npnClassCtrl.sv
module npnClassCtrl
  import npnClassPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] mode,
  output logic       busy,
  output logic       done,
  output strobeT     strobe
);

  localparam logic [PermW-1:0] LastPerm = PermW'(NumPerm - 1);
  localparam logic [NumIn-1:0] LastMask = {NumIn{1'b1}};

  logic             busyQ;
  logic             doneQ;
  modeT             modeQ;
  logic [PermW-1:0] permQ;
  logic [NumIn-1:0] maskQ;
  logic             polQ;

  logic permWrap;
  logic maskWrap;
  logic polWrap;

  always_comb begin
    permWrap = (permQ == LastPerm);
    maskWrap = (modeQ == ModeP) || (maskQ == LastMask);
    polWrap  = !modeQ[1] || polQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      modeQ <= ModeP;
      permQ <= '0;
      maskQ <= '0;
      polQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (start) begin
          busyQ <= 1'b1;
          modeQ <= modeT'(mode);
          permQ <= '0;
          maskQ <= '0;
          polQ  <= 1'b0;
        end
      end else if (!permWrap) begin
        permQ <= permQ + 1'b1;
      end else begin
        permQ <= '0;
        if (!maskWrap) begin
          maskQ <= maskQ + 1'b1;
        end else begin
          maskQ <= '0;
          if (!polWrap) begin
            polQ <= 1'b1;
          end else begin
            polQ  <= 1'b0;
            busyQ <= 1'b0;
            doneQ <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    strobe.load = start && !busyQ;
    strobe.eval = busyQ;
    strobe.perm = permQ;
    strobe.mask = maskQ;
    strobe.pol  = polQ;
  end

  assign busy = busyQ;
  assign done = doneQ;

endmodule

// File: rtl/npnClassDatapath.sv
module npnClassDatapath
  import npnClassPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [TtW-1:0]   truthIn,
  input  strobeT           strobe,
  output logic [TtW-1:0]   canon,
  output logic [PermW-1:0] permIdx,
  output logic [NumIn-1:0] negMask,
  output logic             outNeg,
  output logic [NumIn-1:0] degen
);

  logic [TtW-1:0]   ttQ;
  logic             firstQ;
  logic [TtW-1:0]   bestQ;
  logic [PermW-1:0] bestPermQ;
  logic [NumIn-1:0] bestMaskQ;
  logic             bestPolQ;
  logic [NumIn-1:0] degenQ;

  logic [TtW-1:0]   cand;
  logic             takeCand;
  logic [NumIn-1:0] indep;

  // one cofactor comparator per input variable
  for (genvar k = 0; k < NumIn; k++) begin : gCof
    always_comb begin
      indep[k] = 1'b1;
      for (int i = 0; i < TtW; i++) begin
        if (((i >> k) & 1) == 0) begin
          if (truthIn[i] != truthIn[i | (1 << k)]) indep[k] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    cand     = applyXform(ttQ, strobe.perm, strobe.mask, strobe.pol);
    takeCand = strobe.eval && (firstQ || (cand < bestQ));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ttQ       <= '0;
      firstQ    <= 1'b0;
      bestQ     <= '0;
      bestPermQ <= '0;
      bestMaskQ <= '0;
      bestPolQ  <= 1'b0;
      degenQ    <= '0;
    end else begin
      if (strobe.load) begin
        ttQ    <= truthIn;
        degenQ <= indep;
        firstQ <= 1'b1;
      end else if (strobe.eval) begin
        firstQ <= 1'b0;
      end
      if (takeCand) begin
        bestQ     <= cand;
        bestPermQ <= strobe.perm;
        bestMaskQ <= strobe.mask;
        bestPolQ  <= strobe.pol;
      end
    end
  end

  assign canon   = bestQ;
  assign permIdx = bestPermQ;
  assign negMask = bestMaskQ;
  assign outNeg  = bestPolQ;
  assign degen   = degenQ;

endmodule

// File: rtl/npnClassifier.sv
module npnClassifier
  import npnClassPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [TtW-1:0]   truthIn,
  output logic             busy,
  output logic             done,
  output logic [TtW-1:0]   canon,
  output logic [PermW-1:0] permIdx,
  output logic [NumIn-1:0] negMask,
  output logic             outNeg,
  output logic [NumIn-1:0] degen
);

  strobeT strobe;

  npnClassCtrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .mode   (mode),
    .busy   (busy),
    .done   (done),
    .strobe (strobe)
  );

  npnClassDatapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .truthIn (truthIn),
    .strobe  (strobe),
    .canon   (canon),
    .permIdx (permIdx),
    .negMask (negMask),
    .outNeg  (outNeg),
    .degen   (degen)
  );

endmodule

// File: rtl/npnClassChk.sv
module npnClassChk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic [1:0] mode,
  input logic [7:0] truthIn,
  input logic       busy,
  input logic       done,
  input logic [7:0] canon,
  input logic [2:0] permIdx,
  input logic [2:0] negMask,
  input logic       outNeg,
  input logic [2:0] degen
);

  logic [1:0] modeC;
  logic [7:0] ttC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeC <= 2'd0;
      ttC   <= 8'd0;
    end else if (start && !busy) begin
      modeC <= mode;
      ttC   <= truthIn;
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

  // R2
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(done && busy));

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN) $rose(busy) |-> $past(start));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !done) |-> ($stable(canon) && $stable(permIdx) && $stable(negMask) && $stable(outNeg) && $stable(degen)));

  // R7
  p_mode_ident_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && modeC == 2'd0) |-> (negMask == 3'd0 && !outNeg));

  // R7
  np_mode_pol_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && modeC == 2'd1) |-> !outNeg);

  // R6
  npn_top_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && modeC[1]) |-> !canon[7]);

  // R6
  not_above_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (canon <= ttC));

  // R5
  weight_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !modeC[1]) |-> ($countones(canon) == $countones(ttC)));

  // R7
  perm_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (permIdx < 3'd6));

endmodule

bind npnClassifier npnClassChk chk_i (.*);

// File: tb/npnClassifier_tb_top.sv
`timescale 1ns/1ps
module npnClassifier_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] truthIn = 8'd0;
  logic       busy;
  logic       done;
  logic [7:0] canon;
  logic [2:0] permIdx;
  logic [2:0] negMask;
  logic       outNeg;
  logic [2:0] degen;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  npnClassifier dut_i (.*);

  int permTab [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int refXform(int tt, int p, int m, int o);
    int g = 0;
    for (int i = 0; i < 8; i++) begin
      int y = 0;
      for (int k = 0; k < 3; k++)
        if ((((i ^ m) >> permTab[p][k]) & 1) == 1) y = y | (1 << k);
      g = g | ((((tt >> y) & 1) ^ o) << i);
    end
    return g;
  endfunction

  task automatic runCase(input int tt, input int md, input bit poke);
    int n, best, bp, bm, bo, dg;
    int nm, no;
    nm = (md == 0) ? 1 : 8;
    no = (md >= 2) ? 2 : 1;
    n = 6 * nm * no;
    best = 256; bp = 0; bm = 0; bo = 0;
    for (int o = 0; o < no; o++)
      for (int m = 0; m < nm; m++)
        for (int p = 0; p < 6; p++) begin
          int g = refXform(tt, p, m, o);
          if (g < best) begin best = g; bp = p; bm = m; bo = o; end
        end
    dg = 0;
    for (int k = 0; k < 3; k++) begin
      bit same = 1;
      for (int x = 0; x < 8; x++)
        if (((tt >> x) & 1) != ((tt >> (x ^ (1 << k))) & 1)) same = 0;
      if (same) dg = dg | (1 << k);
    end

    @(negedge clk);
    truthIn = tt[7:0]; mode = md[1:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < n; c++) begin
      // R2 R4: busy for exactly N cycles, no early done
      chk(busy == 1'b1 && done == 1'b0, "R2/R4 busy window", {busy, done}, 2);
      if (poke) begin
        // R3: a second request mid-search must be ignored
        start = (c == 2);
        truthIn = ~tt[7:0];
        mode = 2'd0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(busy == 1'b0 && done == 1'b1, "R2 done pulse", {busy, done}, 1);
    chk(canon == best[7:0], poke ? "R3 canon" : "R6 canon", canon, best);
    chk(permIdx == bp[2:0], "R6 tie/perm", permIdx, bp);
    chk(negMask == bm[2:0], "R7 mask", negMask, bm);
    chk(outNeg == bo[0], "R7 outNeg", outNeg, bo);
    chk(degen == dg[2:0], "R8 degen", degen, dg);
    chk(refXform(tt, permIdx, negMask, outNeg) == canon, "R5 reproduce", refXform(tt, permIdx, negMask, outNeg), canon);
    truthIn = 8'h5A; mode = 2'd3;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      // R9: results hold after done
      chk(done == 1'b0 && busy == 1'b0, "R9 idle", {busy, done}, 0);
      chk(canon == best[7:0] && degen == dg[2:0] && permIdx == bp[2:0], "R9 hold",
          {canon, degen, permIdx}, {best[7:0], dg[2:0], bp[2:0]});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 0 && done == 0 && canon == 0 && permIdx == 0 && negMask == 0 && outNeg == 0 && degen == 0,
        "R1 in reset", {busy, done, canon, degen}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && canon == 0 && degen == 0, "R1 after reset", {busy, done, canon, degen}, 0);
    runCase(8'h00, 0, 0);
    runCase(8'hFF, 0, 0);
    runCase(8'hFF, 2, 0);
    runCase(8'hAA, 0, 0);
    runCase(8'hAA, 1, 0);
    runCase(8'hF0, 0, 0);
    runCase(8'hE8, 2, 0);
    runCase(8'h96, 1, 0);
    runCase(8'h80, 1, 0);
    runCase(8'h80, 2, 0);
    runCase(8'h6C, 0, 1);
    runCase(8'hCA, 3, 0);
    runCase(8'h17, 2, 1);
    runCase(8'h3C, 0, 0);
    for (int j = 0; j < 8; j++) runCase((j * 37 + 11) & 255, j % 4, 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #600000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule